// File: doc/BRIEF.md
# Token-Ring Node Host Register Bank

This block is the register file that a host microcontroller sees when it drives a token-passing network node. The host performs byte-wide reads and writes at eight register addresses. Address 7 is shared by several registers: two sub-address bits in the configuration register choose whether it reaches the tentative identifier, the node identifier or the read-only next-node identifier. The bank holds the node's identity, its configuration, a command port, a status byte, a diagnostic byte and a two-part pointer into the node's packet memory.

The protocol engine that passes the token is outside this block. It reports events to the bank as one-cycle strobes: a next-node identifier update, duplicate-identifier detection, receive activity, token sightings, tentative-identifier hits, excessive negative acknowledgements, receive and transmit completion and reconfiguration. The bank turns these into sticky flags that the host can read. Some flags clear when the host reads them, some clear only on a command, and some clear on both kinds of reset.

There are two resets. The hardware reset is the active-low `hw_rst_n` pin and restores every register. The software reset is held for as long as configuration bit 7 is 1. It restores only the event-driven state. The node identifier, the tentative identifier and the configuration survive it. A node identifier of zero keeps the node engine asleep. A non-zero identifier wakes it, and the transmit-enable configuration bit then decides whether the node may take part in token passing.

Top module: `tr_host_regs`

## Requirements
- R1: After hardware reset, the registers read as follows: tentative ID 0x00, node ID 0x00, next ID 0x00, configuration 0x18, status 0x91, and diagnostic 0x00 apart from bit 0. Bit 0 of the diagnostic byte always follows the `line_active` input.
- R2: The register addresses are 0 (status on read, command on write), 1 (diagnostic), 2 (pointer high), 3 (pointer low) and 4 (configuration); addresses 5 and 6 read 0x00. At address 7, configuration bits [1:0] select the register: 0 selects the tentative ID, 1 the node ID, 2 the next ID (read-only) and 3 nothing, which reads 0x00. Writes at address 7 with selector 2 or 3 have no effect.
- R3: `core_en` and `rx_en` are 1 exactly when the node ID is non-zero. `net_join` is 1 exactly when `core_en` is 1 and configuration bit 2 (transmit enable) is 1.
- R4: A `nxt_upd` strobe loads `nxt_val` into the next ID and sets the new-next flag. This flag drives `irq_new_next` and diagnostic bit 2. A host read of the next ID at address 7 with selector 2 clears the flag. If an update and that read happen in the same cycle, the flag stays set.
- R5: Diagnostic bits 7 (duplicate ID), 6 (receive activity), 5 (token seen) and 3 (tentative hit) are set by their event strobes and cleared by a host read of address 1. A strobe in the same cycle as that read wins. The read leaves bits 4 and 2 unchanged.
- R6: Diagnostic bit 4 (excessive NAK) is set by `ev_excess_nak`. Only command 0x1E or a reset clears it.
- R7: While configuration bit 7 is 1, the next ID, the new-next flag, the diagnostic flags and the status flags are held at their reset values. The node ID, the tentative ID and the configuration keep their values and can still be written.
- R8: Status bit 7 is set by `ev_rx_done` and cleared by command 0x04. Status bit 0 is set by `ev_tx_done` and cleared by command 0x03. Status bit 4 is cleared by command 0x1E. Status bit 3 is set by `ev_recon` and cleared by command 0x1E. Status bits [6:5] show configuration bits [6:5], and status bits [2:1] read 0.
- R9: A write to address 2 only stages the high pointer byte and leaves `ram_addr` unchanged. A write to address 3 loads `ram_addr` with the staged high bits (the low ADDR_W-8 bits of the staged byte) above the written low byte. Address 3 reads back `ram_addr[7:0]`.
- R10: A command write with any code other than 0x1E, 0x03 or 0x04 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| nxt_upd | input | 1 | Strobe from the node engine that updates the next ID |
| nxt_val | input | 8 | New next-node identifier |
| ev_dup_id | input | 1 | Duplicate-identifier event |
| ev_rx_act | input | 1 | Receive-activity event |
| ev_token | input | 1 | Token-seen event |
| ev_tent_hit | input | 1 | Tentative-identifier hit event |
| ev_excess_nak | input | 1 | Excessive-NAK event |
| ev_rx_done | input | 1 | Receive-complete event |
| ev_tx_done | input | 1 | Transmit-complete event |
| ev_recon | input | 1 | Reconfiguration event |
| line_active | input | 1 | Live line-activity level, shown in diagnostic bit 0 |
| core_en | output | 1 | Node engine enable (node ID non-zero) |
| rx_en | output | 1 | Receive path enable |
| net_join | output | 1 | Permission to join token passing |
| irq_new_next | output | 1 | New-next-ID interrupt flag |
| ram_addr | output | ADDR_W | Active packet-memory pointer |

## Verification
The assertions check these rules on every cycle:
- an update always sets the new-next flag, and a read of the next ID on its own clears it;
- a diagnostic read clears the duplicate flag unless a new event arrives in the same cycle;
- only the clear-flags command or a reset lowers the excessive-NAK bit;
- writing the high pointer byte never moves the active pointer;
- a write of an undefined command leaves the status byte unchanged;
- a software reset holds the node ID.

Only the bench's scenarios can show the rest. That covers the full address map and the selector at address 7, and the exact reset bytes. It also covers the difference between the hardware and software reset domains and the end-to-end read values after random mixes of host traffic and engine strobes, which the bench compares against its own model of the registers.

// File: rtl/tr_regs_pkg.sv
package tr_regs_pkg;

  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    RA_STAT = 3'd0,
    RA_DIAG = 3'd1,
    RA_PHI  = 3'd2,
    RA_PLO  = 3'd3,
    RA_CFG  = 3'd4,
    RA_BANK = 3'd7
  } reg_addr_e;

  localparam logic [1:0] SUB_TENT = 2'd0;
  localparam logic [1:0] SUB_NODE = 2'd1;
  localparam logic [1:0] SUB_NEXT = 2'd2;

  localparam logic [REG_W-1:0] CMD_CLR_FLAGS = 8'h1E;
  localparam logic [REG_W-1:0] CMD_TX_GO     = 8'h03;
  localparam logic [REG_W-1:0] CMD_RX_ON     = 8'h04;

  localparam logic [REG_W-1:0] CFG_HW_DEFAULT = 8'h18;
  localparam int CFG_SWRST = 7;
  localparam int CFG_TXEN  = 2;

  typedef struct packed {
    logic clr_flags;
    logic tx_go;
    logic rx_on;
  } cmd_t;

  typedef struct packed {
    logic wr_cmd;
    logic wr_phi;
    logic wr_plo;
    logic wr_cfg;
    logic wr_tent;
    logic wr_node;
    logic rd_diag;
    logic rd_next;
    cmd_t cmd;
  } host_strb_t;

  // Command code to strobe set; unknown codes give no strobe (R10)
  function automatic cmd_t decode_cmd(input logic [REG_W-1:0] code);
    cmd_t c;
    c.clr_flags = (code == CMD_CLR_FLAGS);
    c.tx_go     = (code == CMD_TX_GO);
    c.rx_on     = (code == CMD_RX_ON);
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
      input logic rx, input logic [1:0] tmo, input logic por,
      input logic recon, input logic tx);
    return {rx, tmo, por, recon, 2'b00, tx};
  endfunction

  // sticky[3]=dup, [2]=rx activity, [1]=token, [0]=tentative hit
  function automatic logic [REG_W-1:0] pack_diag(
      input logic [3:0] sticky, input logic exc, input logic nnid,
      input logic line);
    return {sticky[3], sticky[2], sticky[1], exc, sticky[0], nnid, 1'b0, line};
  endfunction

  function automatic logic [REG_W-1:0] bank_read(
      input logic [1:0] sub, input logic [REG_W-1:0] tent,
      input logic [REG_W-1:0] node, input logic [REG_W-1:0] nxt);
    case (sub)
      SUB_TENT: return tent;
      SUB_NODE: return node;
      SUB_NEXT: return nxt;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/tr_host_decode.sv
module tr_host_decode
  import tr_regs_pkg::*;
(
  input  logic [2:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [REG_W-1:0] host_wdata,
  input  logic [1:0]       sub,
  output host_strb_t       strb
);

  logic bank_hit;
  assign bank_hit = (host_addr == RA_BANK);

  always_comb begin
    strb.wr_cmd  = host_wr && (host_addr == RA_STAT);
    strb.wr_phi  = host_wr && (host_addr == RA_PHI);
    strb.wr_plo  = host_wr && (host_addr == RA_PLO);
    strb.wr_cfg  = host_wr && (host_addr == RA_CFG);
    strb.wr_tent = host_wr && bank_hit && (sub == SUB_TENT);
    strb.wr_node = host_wr && bank_hit && (sub == SUB_NODE);
    strb.rd_diag = host_rd && (host_addr == RA_DIAG);
    strb.rd_next = host_rd && bank_hit && (sub == SUB_NEXT);
    strb.cmd     = strb.wr_cmd ? decode_cmd(host_wdata) : '0;
  end

endmodule

// File: rtl/tr_id_bank.sv
module tr_id_bank
  import tr_regs_pkg::*;
(
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             sw_rst,
  input  logic             wr_tent,
  input  logic             wr_node,
  input  logic             rd_next,
  input  logic [REG_W-1:0] wdata,
  input  logic             nxt_upd,
  input  logic [REG_W-1:0] nxt_val,
  output logic [REG_W-1:0] tent_id,
  output logic [REG_W-1:0] node_id,
  output logic [REG_W-1:0] next_id,
  output logic             nnid,
  output logic             core_en
);

  // Hardware-reset-only identity registers
  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      tent_id <= '0;
      node_id <= '0;
    end else begin
      if (wr_tent) tent_id <= wdata;
      if (wr_node) node_id <= wdata;
    end
  end

  // Next ID and its interrupt flag: both reset domains
  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      next_id <= '0;
      nnid    <= 1'b0;
    end else if (sw_rst) begin
      next_id <= '0;
      nnid    <= 1'b0;
    end else begin
      if (nxt_upd) next_id <= nxt_val;
      if (nxt_upd)      nnid <= 1'b1;
      else if (rd_next) nnid <= 1'b0;
    end
  end

  assign core_en = (node_id != '0);

  a_r4_update_sets: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (nxt_upd && !sw_rst) |=> nnid)
    else $error("a_r4_update_sets");

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_next && !nxt_upd) |=> !nnid)
    else $error("a_r4_read_clears");

  a_r3_wake: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (wr_node && wdata != '0) |=> core_en)
    else $error("a_r3_wake");

  a_r3_sleep: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (wr_node && wdata == '0) |=> !core_en)
    else $error("a_r3_sleep");

  a_r7_node_kept: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (sw_rst && !wr_node) |=> (node_id == $past(node_id)))
    else $error("a_r7_node_kept");

endmodule

// File: rtl/tr_flag_bank.sv
module tr_flag_bank
  import tr_regs_pkg::*;
#(
  parameter int N_STICKY = 4
) (
  input  logic                clk,
  input  logic                hw_rst_n,
  input  logic                sw_rst,
  input  logic                rd_diag,
  input  cmd_t                cmd,
  input  logic [N_STICKY-1:0] ev_sticky,
  input  logic                ev_excess_nak,
  input  logic                ev_rx_done,
  input  logic                ev_tx_done,
  input  logic                ev_recon,
  output logic [N_STICKY-1:0] sticky,
  output logic                excnak,
  output logic                st_rx,
  output logic                st_por,
  output logic                st_recon,
  output logic                st_tx
);

  // Read-clear diagnostic flags; a set event beats a clearing read
  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n)         sticky[g] <= 1'b0;
      else if (sw_rst)       sticky[g] <= 1'b0;
      else if (ev_sticky[g]) sticky[g] <= 1'b1;
      else if (rd_diag)      sticky[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      excnak   <= 1'b0;
      st_rx    <= 1'b1;
      st_por   <= 1'b1;
      st_recon <= 1'b0;
      st_tx    <= 1'b1;
    end else if (sw_rst) begin
      excnak   <= 1'b0;
      st_rx    <= 1'b1;
      st_por   <= 1'b1;
      st_recon <= 1'b0;
      st_tx    <= 1'b1;
    end else begin
      if (ev_excess_nak)      excnak <= 1'b1;
      else if (cmd.clr_flags) excnak <= 1'b0;
      if (ev_rx_done)         st_rx <= 1'b1;
      else if (cmd.rx_on)     st_rx <= 1'b0;
      if (ev_tx_done)         st_tx <= 1'b1;
      else if (cmd.tx_go)     st_tx <= 1'b0;
      if (ev_recon)           st_recon <= 1'b1;
      else if (cmd.clr_flags) st_recon <= 1'b0;
      if (cmd.clr_flags)      st_por <= 1'b0;
    end
  end

  a_r6_excnak_hold: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (excnak && !cmd.clr_flags && !sw_rst) |=> excnak)
    else $error("a_r6_excnak_hold");

  a_r5_read_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_diag && !ev_sticky[N_STICKY-1] && !sw_rst) |=> !sticky[N_STICKY-1])
    else $error("a_r5_read_clear");

  a_r5_read_keeps_exc: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_diag && excnak && !cmd.clr_flags && !sw_rst) |=> excnak)
    else $error("a_r5_read_keeps_exc");

  a_r8_rx_set: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (ev_rx_done && !sw_rst) |=> st_rx)
    else $error("a_r8_rx_set");

endmodule

// File: rtl/tr_host_regs.sv
module tr_host_regs
  import tr_regs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              nxt_upd,
  input  logic [7:0]        nxt_val,
  input  logic              ev_dup_id,
  input  logic              ev_rx_act,
  input  logic              ev_token,
  input  logic              ev_tent_hit,
  input  logic              ev_excess_nak,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_recon,
  input  logic              line_active,
  output logic              core_en,
  output logic              rx_en,
  output logic              net_join,
  output logic              irq_new_next,
  output logic [ADDR_W-1:0] ram_addr
);

  localparam int HI_W     = ADDR_W - REG_W;
  localparam int N_STICKY = 4;

  function automatic logic [ADDR_W-1:0] join_ptr(
      input logic [REG_W-1:0] hi, input logic [REG_W-1:0] lo);
    return {hi[HI_W-1:0], lo};
  endfunction

  logic [REG_W-1:0]    cfg;
  logic [REG_W-1:0]    ptr_hi;
  logic [ADDR_W-1:0]   ram_ptr;
  logic                sw_rst;
  host_strb_t          strb;
  logic [REG_W-1:0]    tent_id, node_id, next_id;
  logic                nnid;
  logic [N_STICKY-1:0] sticky;
  logic                excnak, st_rx, st_por, st_recon, st_tx;
  logic [REG_W-1:0]    status_byte, diag_byte;

  assign sw_rst = cfg[CFG_SWRST];

  tr_host_decode u_decode (
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_wdata(host_wdata),
    .sub       (cfg[1:0]),
    .strb      (strb)
  );

  tr_id_bank u_ids (
    .clk     (clk),
    .hw_rst_n(hw_rst_n),
    .sw_rst  (sw_rst),
    .wr_tent (strb.wr_tent),
    .wr_node (strb.wr_node),
    .rd_next (strb.rd_next),
    .wdata   (host_wdata),
    .nxt_upd (nxt_upd),
    .nxt_val (nxt_val),
    .tent_id (tent_id),
    .node_id (node_id),
    .next_id (next_id),
    .nnid    (nnid),
    .core_en (core_en)
  );

  tr_flag_bank #(.N_STICKY(N_STICKY)) u_flags (
    .clk          (clk),
    .hw_rst_n     (hw_rst_n),
    .sw_rst       (sw_rst),
    .rd_diag      (strb.rd_diag),
    .cmd          (strb.cmd),
    .ev_sticky    ({ev_dup_id, ev_rx_act, ev_token, ev_tent_hit}),
    .ev_excess_nak(ev_excess_nak),
    .ev_rx_done   (ev_rx_done),
    .ev_tx_done   (ev_tx_done),
    .ev_recon     (ev_recon),
    .sticky       (sticky),
    .excnak       (excnak),
    .st_rx        (st_rx),
    .st_por       (st_por),
    .st_recon     (st_recon),
    .st_tx        (st_tx)
  );

  // Configuration: hardware reset only
  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n)       cfg <= CFG_HW_DEFAULT;
    else if (strb.wr_cfg) cfg <= host_wdata;
  end

  // Packet memory pointer: no reset, value undefined until written
  always_ff @(posedge clk) begin
    if (strb.wr_phi) ptr_hi  <= host_wdata;
    if (strb.wr_plo) ram_ptr <= join_ptr(ptr_hi, host_wdata);
  end

  assign status_byte = pack_status(st_rx, cfg[6:5], st_por, st_recon, st_tx);
  assign diag_byte   = pack_diag(sticky, excnak, nnid, line_active);

  always_comb begin
    case (host_addr)
      RA_STAT: host_rdata = status_byte;
      RA_DIAG: host_rdata = diag_byte;
      RA_PHI:  host_rdata = ptr_hi;
      RA_PLO:  host_rdata = ram_ptr[REG_W-1:0];
      RA_CFG:  host_rdata = cfg;
      RA_BANK: host_rdata = bank_read(cfg[1:0], tent_id, node_id, next_id);
      default: host_rdata = '0;
    endcase
  end

  assign rx_en        = core_en;
  assign net_join     = core_en && cfg[CFG_TXEN];
  assign irq_new_next = nnid;
  assign ram_addr     = ram_ptr;

  a_r9_hi_stages: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (strb.wr_phi && !strb.wr_plo) |=> $stable(ram_addr))
    else $error("a_r9_hi_stages");

  a_r10_bad_cmd: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (strb.wr_cmd && decode_cmd(host_wdata) == '0 && !sw_rst &&
     !ev_rx_done && !ev_tx_done && !ev_recon) |=> $stable(status_byte))
    else $error("a_r10_bad_cmd");

endmodule

// File: tb/tr_host_regs_tb.sv
module tr_host_regs_tb;

  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        nxt_upd = 1'b0;
  logic [7:0]  nxt_val = '0;
  logic        ev_dup_id = 0, ev_rx_act = 0, ev_token = 0, ev_tent_hit = 0;
  logic        ev_excess_nak = 0, ev_rx_done = 0, ev_tx_done = 0, ev_recon = 0;
  logic        line_active = 0;
  logic        core_en, rx_en, net_join, irq_new_next;
  logic [10:0] ram_addr;

  tr_host_regs #(.ADDR_W(11)) u_dut (
    .clk(clk), .hw_rst_n(hw_rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .nxt_upd(nxt_upd), .nxt_val(nxt_val), .ev_dup_id(ev_dup_id),
    .ev_rx_act(ev_rx_act), .ev_token(ev_token), .ev_tent_hit(ev_tent_hit),
    .ev_excess_nak(ev_excess_nak), .ev_rx_done(ev_rx_done),
    .ev_tx_done(ev_tx_done), .ev_recon(ev_recon), .line_active(line_active),
    .core_en(core_en), .rx_en(rx_en), .net_join(net_join),
    .irq_new_next(irq_new_next), .ram_addr(ram_addr)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench model of the register state
  logic [7:0]  m_tent, m_node, m_cfg, m_next, m_phi;
  logic [10:0] m_ptr;
  logic        m_nnid, m_exc, m_st_rx, m_st_por, m_st_recon, m_st_tx;
  logic [3:0]  m_stk;
  bit          hi_known, ptr_known;

  localparam logic [7:0] EV_DUP = 8'h01, EV_RXA = 8'h02, EV_TOK = 8'h04,
    EV_TENT = 8'h08, EV_EXC = 8'h10, EV_RXD = 8'h20, EV_TXD = 8'h40, EV_REC = 8'h80;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a, input logic line);
    case (a)
      3'd0: return {m_st_rx, m_cfg[6:5], m_st_por, m_st_recon, 2'b00, m_st_tx};
      3'd1: return {m_stk[3], m_stk[2], m_stk[1], m_exc, m_stk[0], m_nnid, 1'b0, line};
      3'd2: return m_phi;
      3'd3: return m_ptr[7:0];
      3'd4: return m_cfg;
      3'd7: case (m_cfg[1:0])
              2'd0: return m_tent;
              2'd1: return m_node;
              2'd2: return m_next;
              default: return 8'h00;
            endcase
      default: return 8'h00;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R8";
      3'd1: return "R5";
      3'd2, 3'd3: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic model_hw_reset();
    m_tent = 0; m_node = 0; m_cfg = 8'h18; m_next = 0; m_nnid = 0;
    m_stk = 0; m_exc = 0; m_st_rx = 1; m_st_por = 1; m_st_recon = 0; m_st_tx = 1;
    hi_known = 0; ptr_known = 0;
  endtask

  // One clock cycle: drive, sample before the edge, advance the model
  task automatic step(input bit w, input bit r, input logic [2:0] a,
                      input logic [7:0] d, input logic [7:0] ev, input bit line,
                      input bit u, input logic [7:0] nv, input string tag);
    logic [7:0] exp_rd;
    bit sw, cmd_clr, cmd_tx, cmd_rx, rd_diag, rd_next;
    logic [3:0] evs;
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
    {ev_recon, ev_tx_done, ev_rx_done, ev_excess_nak,
     ev_tent_hit, ev_token, ev_rx_act, ev_dup_id} = ev;
    line_active = line; nxt_upd = u; nxt_val = nv;
    #1;
    if (r && !((a == 3'd2 && !hi_known) || (a == 3'd3 && !ptr_known))) begin
      exp_rd = model_read(a, line);
      chk((tag == "") ? addr_tag(a) : tag, {8'h0, host_rdata}, {8'h0, exp_rd});
    end
    chk("R3 core_en", {15'h0, core_en}, {15'h0, m_node != 0});
    chk("R3 rx_en", {15'h0, rx_en}, {15'h0, m_node != 0});
    chk("R3 net_join", {15'h0, net_join}, {15'h0, (m_node != 0) && m_cfg[2]});
    chk("R4 irq", {15'h0, irq_new_next}, {15'h0, m_nnid});
    if (ptr_known) chk("R9 ram_addr", {5'h0, ram_addr}, {5'h0, m_ptr});
    // model next state
    sw = m_cfg[7];
    cmd_clr = w && a == 0 && d == 8'h1E;
    cmd_tx  = w && a == 0 && d == 8'h03;
    cmd_rx  = w && a == 0 && d == 8'h04;
    rd_diag = r && a == 1;
    rd_next = r && a == 7 && m_cfg[1:0] == 2;
    evs = {ev[0], ev[1], ev[2], ev[3]};
    if (sw) begin
      m_next = 0; m_nnid = 0; m_stk = 0; m_exc = 0;
      m_st_rx = 1; m_st_por = 1; m_st_recon = 0; m_st_tx = 1;
    end else begin
      if (u) begin m_next = nv; m_nnid = 1; end
      else if (rd_next) m_nnid = 0;
      for (int i = 0; i < 4; i++)
        if (evs[i]) m_stk[i] = 1; else if (rd_diag) m_stk[i] = 0;
      if (ev[4]) m_exc = 1; else if (cmd_clr) m_exc = 0;
      if (ev[5]) m_st_rx = 1; else if (cmd_rx) m_st_rx = 0;
      if (ev[6]) m_st_tx = 1; else if (cmd_tx) m_st_tx = 0;
      if (ev[7]) m_st_recon = 1; else if (cmd_clr) m_st_recon = 0;
      if (cmd_clr) m_st_por = 0;
    end
    if (w && a == 7 && m_cfg[1:0] == 0) m_tent = d;
    if (w && a == 7 && m_cfg[1:0] == 1) m_node = d;
    if (w && a == 3) begin m_ptr = {m_phi[2:0], d}; ptr_known = hi_known; end
    if (w && a == 2) begin m_phi = d; hi_known = 1; end
    if (w && a == 4) m_cfg = d;
    @(negedge clk);
    host_wr = 0; host_rd = 0; nxt_upd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1, 0, a, d, 8'h00, 0, 0, 8'h00, "");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    step(0, 1, a, 8'h00, 8'h00, 0, 0, 8'h00, tag);
  endtask
  task automatic evt(input logic [7:0] ev);
    step(0, 0, 3'd0, 8'h00, ev, 0, 0, 8'h00, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #3 hw_rst_n = 0;
    repeat (3) @(negedge clk);
    hw_rst_n = 1;
    model_hw_reset();

    // R1 reset values
    rd(3'd0, "R1 status");
    rd(3'd4, "R1 cfg");
    step(0, 1, 3'd1, 8'h00, 8'h00, 1, 0, 8'h00, "R1 diag line");
    rd(3'd1, "R1 diag");
    rd(3'd5, "R2 addr5");
    wr(3'd4, 8'h00); rd(3'd7, "R1 tent");
    wr(3'd4, 8'h01); rd(3'd7, "R1 node");
    wr(3'd4, 8'h02); rd(3'd7, "R1 next");

    // R2 writes at selector 2/3 ignored, R3 wake and join
    wr(3'd7, 8'h77); rd(3'd7, "R2 next not writable");
    wr(3'd4, 8'h03); wr(3'd7, 8'h66); rd(3'd7, "R2 sel3");
    wr(3'd4, 8'h01); wr(3'd7, 8'h2A); rd(3'd7, "R3 node");
    wr(3'd4, 8'h05); evt(8'h00);
    wr(3'd4, 8'h01); wr(3'd7, 8'h00); evt(8'h00);
    wr(3'd7, 8'h3C);

    // R4 same-cycle update and clearing read: flag survives
    wr(3'd4, 8'h02);
    step(0, 0, 3'd0, 8'h00, 8'h00, 0, 1, 8'h41, "");
    step(0, 1, 3'd7, 8'h00, 8'h00, 0, 1, 8'h42, "R4 read during update");
    rd(3'd7, "R4 next value");
    rd(3'd1, "R4 diag nnid kept");

    // R5 same-cycle dup event wins over diag read
    evt(EV_DUP | EV_TOK);
    step(0, 1, 3'd1, 8'h00, EV_DUP, 0, 0, 8'h00, "R5 read with event");
    rd(3'd1, "R5 dup survived");
    rd(3'd1, "R5 cleared");

    // R6 excess NAK, R10 undefined command
    evt(EV_EXC | EV_RXD | EV_REC);
    rd(3'd1, "R6 set"); rd(3'd1, "R6 kept after read");
    wr(3'd0, 8'h55); rd(3'd0, "R10 status"); rd(3'd1, "R10 diag");
    wr(3'd0, 8'h04); rd(3'd0, "R8 rx_on");
    wr(3'd0, 8'h03); rd(3'd0, "R8 tx_go");
    wr(3'd0, 8'h1E); rd(3'd1, "R6 cleared"); rd(3'd0, "R8 clr");
    wr(3'd4, 8'h61); rd(3'd0, "R8 mirror");

    // R7 software reset
    step(0, 0, 3'd0, 8'h00, EV_TENT, 0, 1, 8'h09, "");
    wr(3'd4, 8'h81); evt(EV_DUP);
    wr(3'd7, 8'h5A);
    wr(3'd4, 8'h01); rd(3'd7, "R7 node kept");
    rd(3'd1, "R7 diag reset"); rd(3'd0, "R7 status reset");
    wr(3'd4, 8'h02); rd(3'd7, "R7 next reset");

    // R9 pointer staging
    wr(3'd2, 8'h05); wr(3'd3, 8'hA7); rd(3'd3, "R9 low");
    wr(3'd2, 8'h02); evt(8'h00); rd(3'd2, "R9 staged hi");
    wr(3'd3, 8'h10);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      logic [7:0] d, ev;
      int op;
      a  = 3'($urandom % 8);
      d  = 8'($urandom);
      op = int'($urandom % 4);
      if (a == 3'd4 && ($urandom % 16) != 0) d[7] = 1'b0;
      if (a == 3'd0 && ($urandom % 2) == 1)
        case ($urandom % 3) 0: d = 8'h1E; 1: d = 8'h03; default: d = 8'h04; endcase
      ev = 8'($urandom) & 8'($urandom) & 8'($urandom);
      step(op == 0, op == 1, a, d, ev, 1'($urandom), (($urandom % 8) == 0),
           8'($urandom), "");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule